// File: doc/BRIEF.md
# Latency-Insensitive Port Adapter

This block sits between a piece of legacy logic that speaks a FIFO-style streaming handshake and the standard unit ports of a cycle-level simulation fabric. The legacy side reads and writes 32-bit words with one control bit, using exists/read on its receive side and full/write on its transmit side. The fabric side has one input port (ready, read, data) and one output port (ready, write, data), each carrying a 33-bit message. The block packs the legacy word and control bit into messages, unpacks incoming messages, and gates every transfer so that no more than one message crosses each port per target cycle.

Target cycles are framed by a Start input and a Done output. In lockstep mode each Start is closed by Done in the same host cycle, so one host cycle is one target cycle. In dilation mode a Start opens a target cycle that stays open, for as many host cycles as needed, until the wrapped logic raises its finish input. A one-entry hold register keeps an accepted incoming message until the legacy side reads it, so a message taken from the channel is never lost.

Top module: `li_port_adapter`

## Requirements
- R1: An outgoing message carries the legacy control bit at bit 32 and the legacy word at bits 31:0; an incoming message is split the same way, bit 32 to the legacy control output and bits 31:0 to the legacy word output.
- R2: The output port writes only when the legacy side writes, the output channel is ready, a target cycle is open and no message has yet left in that target cycle; the legacy full signal is high exactly when one of the last three conditions fails.
- R3: The input port reads only when the input channel is ready, a target cycle is open, no message has yet been taken in that target cycle, and the hold register is empty or is being read by the legacy side in the same host cycle.
- R4: In either mode at most one message is written and at most one message is read in a single target cycle, however many host cycles it spans.
- R5: In lockstep mode Done equals Start in every host cycle.
- R6: In dilation mode Done is high when a target cycle is open (Start high now, or a Start seen and not yet closed by Done) and the finish input is high; Done never rises without such an open cycle.
- R7: In dilation mode a Start that arrives while a target cycle is still open does not begin a second target cycle.
- R8: Once the hold register holds a message, its word and control bit stay unchanged and exists stays high during every open target cycle until the legacy side reads it.
- R9: Reset empties the hold register and closes any open target cycle: with Start low, exists, read, write and Done are all low.
- R10: While no target cycle is open, no message is read or written and the legacy side sees no exists, whatever the legacy and channel inputs do.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| start_i | input | 1 | Begins a target cycle |
| core_fin_i | input | 1 | Wrapped logic reports its pending work finished (dilation mode) |
| done_o | output | 1 | Ends the current target cycle |
| in_ready_i | input | 1 | Input channel holds a message |
| in_read_o | output | 1 | Takes the message from the input channel |
| in_data_i | input | 33 | Incoming message |
| out_ready_i | input | 1 | Output channel can accept a message |
| out_write_o | output | 1 | Pushes a message into the output channel |
| out_data_o | output | 33 | Outgoing message |
| lg_rx_exists_o | output | 1 | A held message is available to the legacy side |
| lg_rx_read_i | input | 1 | Legacy side consumes the held message |
| lg_rx_word_o | output | 32 | Held message word |
| lg_rx_ctrl_o | output | 1 | Held message control bit |
| lg_tx_full_o | output | 1 | Legacy side may not write this host cycle |
| lg_tx_write_i | input | 1 | Legacy side offers a word |
| lg_tx_word_i | input | 32 | Offered word |
| lg_tx_ctrl_i | input | 1 | Offered control bit |

## Verification
Two pairs of events can land in one host cycle: the legacy side draining the hold register while the channel delivers the next message into it, and Done closing a target cycle while a fresh Start arrives. A dedicated phase holds channel ready, legacy read, Start and finish high together so refill-on-drain happens back to back, while random phases with sparse Start and finish make Done and Start coincide with a cycle already open. The bench's behavioural model predicts each port every host cycle for both a lockstep and a dilation instance, and any difference in read, write, Done or held data is reported.

// File: rtl/li_adapter_pkg.sv
package li_adapter_pkg;

  typedef enum logic {
    MODE_LOCKSTEP = 1'b0,
    MODE_DILATE   = 1'b1
  } li_mode_e;

endpackage

// File: rtl/li_fire_ctrl.sv
module li_fire_ctrl
  import li_adapter_pkg::*;
#(
  parameter li_mode_e MODE = MODE_LOCKSTEP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fin_i,
  output logic active_o,
  output logic done_o
);

  logic pend_q;
  logic pend_d;
  logic open_w;

  assign open_w = start_i | pend_q;

  generate
    if (MODE == MODE_DILATE) begin : g_dilate
      always_comb begin
        pend_d = open_w & ~fin_i;
      end
      assign done_o = open_w & fin_i;
    end else begin : g_lockstep
      always_comb begin
        pend_d = 1'b0 & fin_i;
      end
      assign done_o = start_i;
    end
  endgenerate

  assign active_o = open_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/li_rx_hold.sv
module li_rx_hold #(
  parameter int WORD_W = 32,
  localparam int MSG_W = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              end_i,
  input  logic              ch_ready_i,
  input  logic [MSG_W-1:0]  ch_data_i,
  output logic              ch_read_o,
  output logic              lg_exists_o,
  output logic [WORD_W-1:0] lg_word_o,
  output logic              lg_ctrl_o,
  input  logic              lg_read_i
);

  logic             full_q, full_d;
  logic             used_q, used_d;
  logic [MSG_W-1:0] msg_q;
  logic             drain;
  logic             take;

  always_comb begin
    drain  = lg_read_i & full_q & active_i;
    take   = active_i & ~used_q & ch_ready_i & (~full_q | drain);
    full_d = take | (full_q & ~drain);
    used_d = end_i ? 1'b0 : (used_q | take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      used_q <= 1'b0;
      msg_q  <= '0;
    end else begin
      full_q <= full_d;
      used_q <= used_d;
      if (take) begin
        msg_q <= ch_data_i;
      end
    end
  end

  assign ch_read_o   = take;
  assign lg_exists_o = full_q & active_i;
  assign lg_ctrl_o   = msg_q[WORD_W];
  assign lg_word_o   = msg_q[WORD_W-1:0];

endmodule

// File: rtl/li_tx_gate.sv
module li_tx_gate #(
  parameter int WORD_W = 32,
  localparam int MSG_W = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              end_i,
  input  logic              ch_ready_i,
  output logic              ch_write_o,
  output logic [MSG_W-1:0]  ch_data_o,
  input  logic              lg_write_i,
  input  logic [WORD_W-1:0] lg_word_i,
  input  logic              lg_ctrl_i,
  output logic              lg_full_o
);

  logic used_q, used_d;
  logic room;
  logic push;

  always_comb begin
    room   = ch_ready_i & active_i & ~used_q;
    push   = lg_write_i & room;
    used_d = end_i ? 1'b0 : (used_q | push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= 1'b0;
    end else begin
      used_q <= used_d;
    end
  end

  assign lg_full_o  = ~room;
  assign ch_write_o = push;
  assign ch_data_o  = {lg_ctrl_i, lg_word_i};

endmodule

// File: rtl/li_port_adapter.sv
module li_port_adapter
  import li_adapter_pkg::*;
#(
  parameter li_mode_e MODE   = MODE_LOCKSTEP,
  parameter int       WORD_W = 32,
  localparam int      MSG_W  = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              core_fin_i,
  output logic              done_o,
  input  logic              in_ready_i,
  output logic              in_read_o,
  input  logic [MSG_W-1:0]  in_data_i,
  input  logic              out_ready_i,
  output logic              out_write_o,
  output logic [MSG_W-1:0]  out_data_o,
  output logic              lg_rx_exists_o,
  input  logic              lg_rx_read_i,
  output logic [WORD_W-1:0] lg_rx_word_o,
  output logic              lg_rx_ctrl_o,
  output logic              lg_tx_full_o,
  input  logic              lg_tx_write_i,
  input  logic [WORD_W-1:0] lg_tx_word_i,
  input  logic              lg_tx_ctrl_i
);

  logic active;
  logic done;

  li_fire_ctrl #(.MODE(MODE)) u_fire (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .fin_i    (core_fin_i),
    .active_o (active),
    .done_o   (done)
  );

  li_rx_hold #(.WORD_W(WORD_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .end_i       (done),
    .ch_ready_i  (in_ready_i),
    .ch_data_i   (in_data_i),
    .ch_read_o   (in_read_o),
    .lg_exists_o (lg_rx_exists_o),
    .lg_word_o   (lg_rx_word_o),
    .lg_ctrl_o   (lg_rx_ctrl_o),
    .lg_read_i   (lg_rx_read_i)
  );

  li_tx_gate #(.WORD_W(WORD_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .end_i      (done),
    .ch_ready_i (out_ready_i),
    .ch_write_o (out_write_o),
    .ch_data_o  (out_data_o),
    .lg_write_i (lg_tx_write_i),
    .lg_word_i  (lg_tx_word_i),
    .lg_ctrl_i  (lg_tx_ctrl_i),
    .lg_full_o  (lg_tx_full_o)
  );

  assign done_o = done;

endmodule

// File: rtl/li_port_adapter_chk.sv
module li_port_adapter_chk
  import li_adapter_pkg::*;
#(
  parameter li_mode_e MODE   = MODE_LOCKSTEP,
  parameter int       WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              done_o,
  input logic              in_ready_i,
  input logic              in_read_o,
  input logic              out_ready_i,
  input logic              out_write_o,
  input logic              lg_rx_exists_o,
  input logic              lg_rx_read_i,
  input logic [WORD_W-1:0] lg_rx_word_o,
  input logic              lg_rx_ctrl_o
);

  logic open_q, rx_seen_q, tx_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      rx_seen_q <= 1'b0;
      tx_seen_q <= 1'b0;
    end else begin
      open_q    <= done_o ? 1'b0 : (open_q | start_i);
      rx_seen_q <= done_o ? 1'b0 : (rx_seen_q | in_read_o);
      tx_seen_q <= done_o ? 1'b0 : (tx_seen_q | out_write_o);
    end
  end

  AST_TX_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_write_o |-> out_ready_i); // R2
  AST_RX_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    in_read_o |-> in_ready_i); // R3
  AST_ONE_RX_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_read_o |-> !rx_seen_q); // R4
  AST_ONE_TX_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_write_o |-> !tx_seen_q); // R4
  AST_LOCKSTEP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_LOCKSTEP) |-> (done_o == start_i)); // R5
  AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (start_i || open_q)); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lg_rx_exists_o && !lg_rx_read_i) |=> $stable({lg_rx_ctrl_o, lg_rx_word_o})); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i || open_q) |-> !(out_write_o || in_read_o || lg_rx_exists_o)); // R10

endmodule

bind li_port_adapter li_port_adapter_chk #(.MODE(MODE), .WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .done_o         (done_o),
  .in_ready_i     (in_ready_i),
  .in_read_o      (in_read_o),
  .out_ready_i    (out_ready_i),
  .out_write_o    (out_write_o),
  .lg_rx_exists_o (lg_rx_exists_o),
  .lg_rx_read_i   (lg_rx_read_i),
  .lg_rx_word_o   (lg_rx_word_o),
  .lg_rx_ctrl_o   (lg_rx_ctrl_o)
);

// File: tb/li_port_adapter_test.sv
module li_port_adapter_test;
  import li_adapter_pkg::*;

  localparam int W  = 32;
  localparam int MW = W + 1;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic          start, fin, in_ready, out_ready, rx_read, tx_write, tx_ctrl;
  logic [MW-1:0] in_data;
  logic [W-1:0]  tx_word;

  logic          done_w   [2];
  logic          rd_w     [2];
  logic          wr_w     [2];
  logic [MW-1:0] odata_w  [2];
  logic          exists_w [2];
  logic [W-1:0]  rword_w  [2];
  logic          rctrl_w  [2];
  logic          full_w   [2];

  li_port_adapter #(.MODE(MODE_LOCKSTEP), .WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .core_fin_i(fin), .done_o(done_w[0]),
    .in_ready_i(in_ready), .in_read_o(rd_w[0]), .in_data_i(in_data),
    .out_ready_i(out_ready), .out_write_o(wr_w[0]), .out_data_o(odata_w[0]),
    .lg_rx_exists_o(exists_w[0]), .lg_rx_read_i(rx_read), .lg_rx_word_o(rword_w[0]),
    .lg_rx_ctrl_o(rctrl_w[0]), .lg_tx_full_o(full_w[0]), .lg_tx_write_i(tx_write),
    .lg_tx_word_i(tx_word), .lg_tx_ctrl_i(tx_ctrl)
  );

  li_port_adapter #(.MODE(MODE_DILATE), .WORD_W(W)) uut_dil (
    .clk(clk), .rst_n(rst_n), .start_i(start), .core_fin_i(fin), .done_o(done_w[1]),
    .in_ready_i(in_ready), .in_read_o(rd_w[1]), .in_data_i(in_data),
    .out_ready_i(out_ready), .out_write_o(wr_w[1]), .out_data_o(odata_w[1]),
    .lg_rx_exists_o(exists_w[1]), .lg_rx_read_i(rx_read), .lg_rx_word_o(rword_w[1]),
    .lg_rx_ctrl_o(rctrl_w[1]), .lg_tx_full_o(full_w[1]), .lg_tx_write_i(tx_write),
    .lg_tx_word_i(tx_word), .lg_tx_ctrl_i(tx_ctrl)
  );

  // behavioural reference state, one slot per instance
  bit            m_pend [2];
  bit            m_hv   [2];
  bit            m_rxu  [2];
  bit            m_txu  [2];
  logic [MW-1:0] m_msg  [2];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic eval_cycle();
    for (int m = 0; m < 2; m++) begin
      bit act, dn, ex, drain, rd, full, wr;
      if (!rst_n) begin
        m_pend[m] = 0; m_hv[m] = 0; m_rxu[m] = 0; m_txu[m] = 0; m_msg[m] = '0;
      end
      act   = start | m_pend[m];
      dn    = (m == 1) ? (act & fin) : start;
      ex    = m_hv[m] & act;
      drain = rx_read & ex;
      rd    = act & ~m_rxu[m] & in_ready & (~m_hv[m] | drain);
      full  = ~(out_ready & act & ~m_txu[m]);
      wr    = tx_write & ~full;
      check((m == 1) ? "R6,R7 done" : "R5 done", 64'(done_w[m]), 64'(dn));
      check("R3,R4 in_read", 64'(rd_w[m]), 64'(rd));
      check("R2,R4 out_write", 64'(wr_w[m]), 64'(wr));
      check("R2 tx_full", 64'(full_w[m]), 64'(full));
      check("R1 out_data", 64'(odata_w[m]), 64'({tx_ctrl, tx_word}));
      check("R8 rx_exists", 64'(exists_w[m]), 64'(ex));
      check("R1,R8 rx_msg", 64'({rctrl_w[m], rword_w[m]}), 64'(m_msg[m]));
      if (!act) check("R10 idle", 64'({rd_w[m], wr_w[m], exists_w[m]}), 64'(0));
      if (!rst_n && !start)
        check("R9 reset", 64'({done_w[m], rd_w[m], wr_w[m], exists_w[m]}), 64'(0));
      if (rst_n) begin
        if (dn) begin
          m_rxu[m] = 0; m_txu[m] = 0;
        end else begin
          m_rxu[m] = m_rxu[m] | rd; m_txu[m] = m_txu[m] | wr;
        end
        if (rd) begin
          m_hv[m] = 1; m_msg[m] = in_data;
        end else if (drain) begin
          m_hv[m] = 0;
        end
        m_pend[m] = (m == 1) ? (act & ~fin) : 1'b0;
      end
    end
  endtask

  function automatic bit pick(input int pct);
    return ($urandom_range(99) < pct);
  endfunction

  task automatic cycles(input int n, input int ps, input int pf, input int pio);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start     = pick(ps);
      fin       = pick(pf);
      in_ready  = pick(pio);
      out_ready = pick(pio);
      rx_read   = pick(pio);
      tx_write  = pick(pio);
      tx_ctrl   = pick(50);
      tx_word   = $urandom;
      in_data   = {1'(pick(50)), 32'($urandom)};
      #1;
      eval_cycle();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 0; fin = 0; in_ready = 0; out_ready = 0; rx_read = 0; tx_write = 0;
    tx_ctrl = 0; tx_word = '0; in_data = '0;
    // R9: reset state with busy inputs but no Start
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_ready = 1; out_ready = 1; tx_write = 1; rx_read = 1; fin = 1;
      #1;
      eval_cycle();
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    eval_cycle();
    cycles(400, 100, 50, 50);   // R5: Start every host cycle
    cycles(2000, 30, 35, 60);   // R6,R7: sparse Start and finish
    cycles(200, 100, 100, 100); // R3,R8: drain and refill in one host cycle
    cycles(300, 60, 10, 90);    // R4: long dilated cycles with busy channels
    cycles(150, 0, 50, 100);    // R10: no target cycle opened
    cycles(300, 40, 40, 70);
    @(negedge clk);             // R9: reset in mid-run
    rst_n = 1'b0;
    start = 0;
    #1;
    eval_cycle();
    @(negedge clk);
    #1;
    eval_cycle();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    eval_cycle();
    cycles(500, 50, 50, 60);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule